// File: doc/BRIEF.md
# Dual-Mode Serial Baud Generator

This block produces the timing enables for a serial port that runs either as an asynchronous UART or as a synchronous master driving its own shift clock. An 8-bit divisor value X, loaded through a one-cycle register-write strobe, sets the rate. A fixed divide-by-4 prescaler feeds an 8-bit reloading down-counter, which gives a base tick every 4·(X+1) clock cycles. In synchronous master mode that base tick is the bit-rate tick. In asynchronous mode the base tick is brought out as a 16x oversampling tick for a receiver, and every sixteenth base tick is also a bit-rate tick, so one bit lasts 64·(X+1) clock cycles.

A small controller with two states, HALT and RUN, gates the chain. HALT is entered from reset and whenever the enable input is low. In HALT every stage is held cleared. The HALT-to-RUN transition is taken on the first clock edge that samples the enable high. The RUN-to-HALT transition is taken on the first edge that samples it low. Inside RUN, a divisor write is a restart and not a separate state: the prescaler, the down-counter and the divide-by-16 stage are cleared on the same edge, and the down-counter is loaded with the newly written value. The first tick after a write therefore comes one full new period later. A write made in the very cycle a tick was due cancels that tick. With a 16 MHz clock, asynchronous mode and X = 25, one bit lasts 1664 cycles, which gives about 9615 baud.

Top module: `dual_baud_gen`

## Requirements
- R1: After reset the divisor readback `divisor_q` is 0x00 and both `bit_tick` and `os_tick` are low.
- R2: One clock edge after a write (`wr_en` high at that edge), `divisor_q` equals the value that was on `wr_data`.
- R3: In synchronous mode (`sync_mode` = 1), with the generator enabled, successive `bit_tick` pulses are exactly 4·(X+1) cycles apart.
- R4: In asynchronous mode (`sync_mode` = 0), successive `bit_tick` pulses are exactly 64·(X+1) cycles apart.
- R5: In asynchronous mode, `os_tick` pulses every 4·(X+1) cycles, and `bit_tick` is high together with every 16th `os_tick`, counted from the restart. In synchronous mode `os_tick` stays low.
- R6: The write edge restarts the generator. The first `bit_tick` after it is seen 4·(X+1) edges later in synchronous mode and 64·(X+1) edges later in asynchronous mode, where X is the new value. This holds even when the write lands partway through a period.
- R7: Each `bit_tick` and `os_tick` pulse is high for exactly one clock cycle.
- R8: While `en` is low, no tick is produced. The first `bit_tick` after `en` is first sampled high comes one full period after that edge.
- R9: In asynchronous mode with X = 25, the bit period is 1664 cycles.
- R10: A write sampled on the same edge at which a tick was due cancels that tick, and the restart period is counted from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| en | input | 1 | Runs the generator while high |
| sync_mode | input | 1 | 0 = asynchronous (divide by 64·(X+1)), 1 = synchronous master (divide by 4·(X+1)) |
| wr_en | input | 1 | Divisor write strobe, one cycle |
| wr_data | input | 8 | New divisor value X |
| bit_tick | output | 1 | One-cycle enable at the bit rate |
| os_tick | output | 1 | One-cycle 16x oversampling enable, asynchronous mode only |
| divisor_q | output | 8 | Readback of the divisor register |

## Verification
The two functions that can meet in one cycle are a divisor write and the tick that the running count was about to emit. The bench lets the generator settle to a steady period, steps forward until the edge at which the next tick is due, and asserts the write strobe for exactly that edge. The result is judged correct if no tick appears on that edge, and the next tick arrives exactly one new period after the write edge, as measured in clock cycles.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

    // Controller states of the generator.
    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } bg_state_e;

    // Division selection; the value follows the sync_mode pin.
    typedef enum logic [0:0] {
        MODE_ASYNC = 1'b0,
        MODE_SYNC  = 1'b1
    } bg_mode_e;

endpackage

// File: rtl/bg_prescale.sv
// Fixed prescaler: emits a pulse once every PRE_DIV enabled cycles.
module bg_prescale #(
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic pre_pulse
);
    localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    assign pre_pulse = run && !clear && (phase_q == LAST);

endmodule

// File: rtl/bg_reload_ctr.sv
// Reloading down-counter: on each step it counts down and reloads at zero.
module bg_reload_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             zero_hit
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= load_val;
        end else if (step) begin
            count_q <= (count_q == '0) ? load_val : count_q - 1'b1;
        end
    end

    assign zero_hit = step && (count_q == '0);

endmodule

// File: rtl/bg_os_div.sv
// Divide-by-RATIO stage on the base tick; flags the last step of each group.
module bg_os_div #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic wrap
);
    localparam int OS_W = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [OS_W-1:0] LAST = OS_W'(RATIO - 1);

    logic [OS_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end
    end

    assign wrap = step && (idx_q == LAST);

endmodule

// File: rtl/dual_baud_gen.sv
module dual_baud_gen
    import baudgen_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int PRE_DIV  = 4,
    parameter int OS_RATIO = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sync_mode,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    output logic             bit_tick,
    output logic             os_tick,
    output logic [DIV_W-1:0] divisor_q
);
    bg_state_e        state_q;
    bg_state_e        state_d;
    bg_mode_e         mode;
    logic             clear;
    logic             run;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] load_val;
    logic             pre_pulse;
    logic             base_evt;
    logic             os_wrap;
    logic             bit_evt;
    logic             os_evt;
    logic             bit_tick_q;
    logic             os_tick_q;

    assign mode = bg_mode_e'(sync_mode);

    // Divisor register; reset clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (wr_en) begin
            div_q <= wr_data;
        end
    end

    // The value being written takes effect on the same edge.
    assign load_val = wr_en ? wr_data : div_q;

    // Controller state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and controller outputs.
    always_comb begin
        state_d = state_q;
        clear   = 1'b1;
        run     = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                if (en) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!en) begin
                    state_d = ST_HALT;
                end else begin
                    run   = 1'b1;
                    clear = wr_en;
                end
            end
            default: state_d = ST_HALT;
        endcase
    end

    bg_prescale #(
        .PRE_DIV (PRE_DIV)
    ) i_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .run       (run),
        .pre_pulse (pre_pulse)
    );

    bg_reload_ctr #(
        .CNT_W (DIV_W)
    ) i_reload (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .load_val (load_val),
        .step     (pre_pulse),
        .zero_hit (base_evt)
    );

    bg_os_div #(
        .RATIO (OS_RATIO)
    ) i_os_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .step  (os_evt),
        .wrap  (os_wrap)
    );

    assign os_evt  = base_evt && (mode == MODE_ASYNC);
    assign bit_evt = (mode == MODE_SYNC) ? base_evt : os_wrap;

    // Registered single-cycle tick outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_tick_q <= 1'b0;
            os_tick_q  <= 1'b0;
        end else if (clear) begin
            bit_tick_q <= 1'b0;
            os_tick_q  <= 1'b0;
        end else begin
            bit_tick_q <= bit_evt;
            os_tick_q  <= os_evt;
        end
    end

    assign bit_tick  = bit_tick_q;
    assign os_tick   = os_tick_q;
    assign divisor_q = div_q;

endmodule

// File: rtl/bg_checker.sv
module bg_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             sync_mode,
    input logic             wr_en,
    input logic [DIV_W-1:0] wr_data,
    input logic             bit_tick,
    input logic             os_tick,
    input logic [DIV_W-1:0] divisor_q
);
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (divisor_q == $past(wr_data)));

    p_no_os_in_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |-> !$past(sync_mode));

    p_bit_on_os_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !$past(sync_mode)) |-> os_tick);

    p_bit_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    p_os_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |=> !os_tick);

    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!bit_tick && !os_tick));

    p_write_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (!bit_tick && !os_tick));

endmodule

bind dual_baud_gen bg_checker #(
    .DIV_W (DIV_W)
) i_bg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .sync_mode (sync_mode),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .bit_tick  (bit_tick),
    .os_tick   (os_tick),
    .divisor_q (divisor_q)
);

// File: tb/test_dual_baud_gen.sv
`timescale 1ns/1ps
module test_dual_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       sync_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       bit_tick;
    logic       os_tick;
    logic [7:0] divisor_q;

    int checks = 0;
    int errors = 0;
    localparam int LIMIT = 20000;

    always #4 clk = ~clk;

    dual_baud_gen i_dual_baud_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .sync_mode (sync_mode),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .bit_tick  (bit_tick),
        .os_tick   (os_tick),
        .divisor_q (divisor_q)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Write at one edge; returns at the negedge right after the write edge.
    task automatic do_write(input int x);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 8'(x);
        @(negedge clk);
        wr_en   = 1'b0;
        check(divisor_q == 8'(x), "R2", "divisor readback", divisor_q, x);
    endtask

    // Steps negedges from the current one until bit_tick is seen.
    task automatic wait_bit(output int gap, output int os_seen);
        gap = 0;
        os_seen = 0;
        do begin
            @(negedge clk);
            gap++;
            if (os_tick) os_seen++;
        end while (!bit_tick && gap < LIMIT);
    endtask

    task automatic t_reset();
        check(divisor_q == 8'h00, "R1", "divisor after reset", divisor_q, 0);
        check(bit_tick == 1'b0, "R1", "bit_tick after reset", bit_tick, 0);
        check(os_tick == 1'b0, "R1", "os_tick after reset", os_tick, 0);
    endtask

    task automatic t_sync(input int x);
        int gap;
        int os_n;
        int p = 4 * (x + 1);
        sync_mode = 1'b1;
        en = 1'b1;
        do_write(x);
        wait_bit(gap, os_n);
        check(gap == p, "R6", "sync first tick after write", gap, p);
        check(os_n == 0, "R5", "os_tick in sync mode", os_n, 0);
        wait_bit(gap, os_n);
        check(gap == p, "R3", "sync tick spacing", gap, p);
        @(negedge clk);
        check(bit_tick == 1'b0, "R7", "sync tick width", bit_tick, 0);
    endtask

    task automatic t_async(input int x);
        int gap;
        int os_n;
        int first_os;
        int p = 64 * (x + 1);
        sync_mode = 1'b0;
        en = 1'b1;
        do_write(x);
        gap = 0;
        os_n = 0;
        first_os = -1;
        do begin
            @(negedge clk);
            gap++;
            if (os_tick) begin
                os_n++;
                if (first_os < 0) first_os = gap;
            end
        end while (!bit_tick && gap < LIMIT);
        check(gap == p, "R6", "async first bit tick after write", gap, p);
        check(first_os == 4 * (x + 1), "R5", "first os tick", first_os, 4 * (x + 1));
        check(os_n == 16 && os_tick, "R5", "os ticks up to bit tick", os_n, 16);
        @(negedge clk);
        check(bit_tick == 1'b0 && os_tick == 1'b0, "R7", "async tick width",
              int'(bit_tick) + int'(os_tick), 0);
        wait_bit(gap, os_n);
        gap++;
        check(gap == p, "R4", "async bit spacing", gap, p);
        if (x == 25) check(gap == 1664, "R9", "9615 baud period", gap, 1664);
    endtask

    // Write partway through a period.
    task automatic t_midwrite(input bit sm, input int x0, input int x1, input int skip);
        int gap;
        int os_n;
        int p1 = (sm ? 4 : 64) * (x1 + 1);
        sync_mode = sm;
        en = 1'b1;
        do_write(x0);
        wait_bit(gap, os_n);
        repeat (skip) @(negedge clk);
        do_write(x1);
        wait_bit(gap, os_n);
        check(gap == p1, "R6", "restart after mid-period write", gap, p1);
    endtask

    // Write on the very edge a tick was due.
    task automatic t_collide(input int x0, input int x1);
        int gap;
        int os_n;
        int p0 = 4 * (x0 + 1);
        int p1 = 4 * (x1 + 1);
        sync_mode = 1'b1;
        en = 1'b1;
        do_write(x0);
        wait_bit(gap, os_n);
        repeat (p0 - 1) @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 8'(x1);
        @(negedge clk);
        wr_en = 1'b0;
        check(bit_tick == 1'b0, "R10", "due tick cancelled by write", bit_tick, 0);
        wait_bit(gap, os_n);
        check(gap == p1, "R10", "period after colliding write", gap, p1);
    endtask

    task automatic t_enable(input int x);
        int gap;
        int os_n;
        int seen = 0;
        int p = 4 * (x + 1);
        sync_mode = 1'b1;
        en = 1'b1;
        do_write(x);
        en = 1'b0;
        repeat (200) begin
            @(negedge clk);
            if (bit_tick || os_tick) seen++;
        end
        check(seen == 0, "R8", "ticks while disabled", seen, 0);
        en = 1'b1;
        @(negedge clk);
        wait_bit(gap, os_n);
        check(gap == p, "R8", "first tick after enable", gap, p);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sync(0);
        t_sync(25);
        t_sync(255);
        t_async(0);
        t_async(25);
        t_async(255);
        t_midwrite(1'b1, 9, 3, 17);
        t_midwrite(1'b0, 1, 2, 50);
        t_collide(2, 5);
        t_enable(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule